// File: doc/BRIEF.md
# Serial Audio Clock Generator

This block makes the two timing signals of a stereo serial audio link: a bit clock and a left/right frame clock. It runs entirely on the master clock. As clock master it divides the master clock by two or four to form the bit clock. It then counts bit periods to form a frame of 32, 64 or 128 bits, and the frame clock changes level at the middle of each frame. As clock slave it drives neither pin. It resynchronises the codec's bit and frame clocks into the master-clock domain instead.

In both modes it gives the data shifters the same three signals. Two are single-cycle strobes that mark the data launch edge and the data capture edge. The third is a left/right word indicator. The polarity of either pin can be inverted. An optional gating mode parks the bit clock at its idle level during the bit slots of each half frame that carry no data. A new division ratio is held back until the next frame starts, so no shortened clock pulse appears on a pin.

Top module: `audclk_gen`

## Requirements
- R1: The bit-clock divide select `cfg_bdiv_sel` sets the bit-clock period in master mode. A value of 0 gives 2 master cycles and a value of 1 gives 4. Each period is low for its first half and high for its second half, before polarity is applied.
- R2: The frame select `cfg_fdiv_sel` sets the frame length: 0 gives 32 bit periods, 1 gives 64, and 2 or 3 give 128. The internal left/right level is 0 (left) for the first half of the frame and 1 (right) for the second half. It changes only in the cycle of a launch strobe.
- R3: With `cfg_master`=1 both output enables are 1. With `cfg_master`=0 both output enables are 0 and the master divider stays idle. In slave mode the strobes come from edges of `bclk_in` after a two-flop synchroniser. `frame_lr` then follows `lrclk_in` two cycles late, corrected for the frame polarity.
- R4: With `cfg_bclk_inv`=0 the bit-clock pin falls at each launch. With `cfg_bclk_inv`=1 the pin is inverted. With `cfg_frame_inv`=0 the frame pin is low for the left word. With `cfg_frame_inv`=1 it is high for the left word.
- R5: With `cfg_free_run`=0 the bit-clock pin is held at its idle level (internal high) during every bit slot whose position inside its half frame is 24 or more. With `cfg_free_run`=1 the bit clock runs in every slot.
- R6: While `enable` is low there are no strobes, the internal bit clock sits high and the internal frame level sits at left. The first launch strobe appears in the first cycle after `enable` is seen high.
- R7: `launch_stb` is high for exactly one cycle, in the cycle the internal bit clock falls. `capture_stb` is high in the cycle it rises. The two strobes are never high together.
- R8: A change of either ratio select while running takes effect only from the first launch of the next frame.
- R9: During reset and for two cycles after it is released, every output shows its idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Global run enable |
| cfg_master | input | 1 | 1: block drives both clocks; 0: clocks come from the codec |
| cfg_bclk_inv | input | 1 | Bit-clock polarity (selects which pin edge launches data) |
| cfg_frame_inv | input | 1 | Frame-clock polarity (selects which level marks the left word) |
| cfg_free_run | input | 1 | 1: bit clock runs continuously; 0: gated outside data slots |
| cfg_bdiv_sel | input | 1 | Master-to-bit ratio: 0 = 2, 1 = 4 |
| cfg_fdiv_sel | input | 2 | Bit-to-frame ratio: 0 = 32, 1 = 64, 2/3 = 128 |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Bit-clock pin value |
| bclk_oe | output | 1 | Bit-clock pin drive enable |
| lrclk_o | output | 1 | Frame-clock pin value |
| lrclk_oe | output | 1 | Frame-clock pin drive enable |
| launch_stb | output | 1 | One-cycle strobe at the data launch edge |
| capture_stb | output | 1 | One-cycle strobe at the data capture edge |
| frame_lr | output | 1 | Current word: 0 left, 1 right |

## Verification
Some properties are checked on every cycle by assertions:
- the two strobes never coincide;
- a launch strobe never repeats in the next cycle;
- each edge of the internal bit clock has the strobe that belongs to it;
- the frame level moves only at a launch or on disable;
- the bit position stays inside the active frame;
- the active ratio changes only at a frame start;
- the divider is quiet after `enable` drops.

Other behaviour only the bench scenarios can show, by comparison against a behavioural model:
- the exact periods for each ratio pair;
- where gating starts inside a half frame;
- the polarity of each pin;
- that a mid-frame ratio change waits for the frame boundary;
- the slave-mode synchroniser latency.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int MAX_FRAME = 128;
  localparam int BPOS_W    = $clog2(MAX_FRAME);

  typedef logic [BPOS_W-1:0] bitpos_t;

  // last bit index of a frame for a frame-ratio select
  function automatic bitpos_t frame_last(input logic [1:0] sel);
    case (sel)
      2'd0:    frame_last = bitpos_t'(31);
      2'd1:    frame_last = bitpos_t'(63);
      default: frame_last = bitpos_t'(MAX_FRAME - 1);
    endcase
  endfunction

  // bit periods in half a frame
  function automatic bitpos_t frame_half(input logic [1:0] sel);
    case (sel)
      2'd0:    frame_half = bitpos_t'(16);
      2'd1:    frame_half = bitpos_t'(32);
      default: frame_half = bitpos_t'(MAX_FRAME / 2);
    endcase
  endfunction
endpackage

// File: rtl/audclk_bitdiv.sv
module audclk_bitdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic div4,
  output logic launch_now,
  output logic capture_now,
  output logic launch_q,
  output logic capture_q,
  output logic raw_q
);
  localparam int CNT_W = 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_last, cnt_half;
  logic             run_q, run_d, raw_d;

  always_comb begin
    cnt_last = div4 ? CNT_W'(3) : CNT_W'(1);
    cnt_half = div4 ? CNT_W'(2) : CNT_W'(1);
    if (!run_q)                cnt_d = '0;
    else if (cnt_q == cnt_last) cnt_d = '0;
    else                       cnt_d = cnt_q + CNT_W'(1);
    launch_now  = en && (cnt_d == '0);
    capture_now = en && (cnt_d == cnt_half);
    run_d       = en;
    raw_d       = en ? (cnt_d >= cnt_half) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      raw_q     <= 1'b1;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
    end else begin
      run_q     <= run_d;
      cnt_q     <= en ? cnt_d : '0;
      raw_q     <= raw_d;
      launch_q  <= launch_now;
      capture_q <= capture_now;
    end
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_q && capture_q));
  p_launch_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |=> !launch_q);
  p_fall_has_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw_q) |-> launch_q);
  p_rise_has_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> (capture_q || $past(!en)));
  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!launch_q && !capture_q && raw_q));
endmodule

// File: rtl/audclk_framediv.sv
module audclk_framediv
  import audclk_pkg::*;
#(
  parameter int ACTIVE_BITS = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       launch_now,
  input  logic       cfg_div4,
  input  logic [1:0] cfg_fsel,
  input  logic       free_run,
  output logic       act_div4_q,
  output logic       lr_q,
  output logic       gate_q
);
  localparam bitpos_t ACT_LIM = bitpos_t'(ACTIVE_BITS);

  bitpos_t    bitpos_q, bitpos_d, fs_last, fs_half, offset;
  logic [1:0] act_fsel_q;
  logic       run_q, run_d, wrap, frame_start, act_load, lr_d, gate_d;

  always_comb begin
    fs_last     = frame_last(act_fsel_q);
    fs_half     = frame_half(act_fsel_q);
    wrap        = !run_q || (bitpos_q == fs_last);
    frame_start = launch_now && wrap;
    act_load    = !en || frame_start;
    run_d       = en && (run_q || launch_now);
    if (!en)             bitpos_d = '0;
    else if (launch_now) bitpos_d = wrap ? '0 : bitpos_q + bitpos_t'(1);
    else                 bitpos_d = bitpos_q;
    offset = bitpos_d & (fs_half - bitpos_t'(1));
    if (!en)             lr_d = 1'b0;
    else if (launch_now) lr_d = (bitpos_d >= fs_half);
    else                 lr_d = lr_q;
    if (!en)             gate_d = 1'b0;
    else if (launch_now) gate_d = !free_run && (offset >= ACT_LIM);
    else                 gate_d = gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      bitpos_q   <= '0;
      lr_q       <= 1'b0;
      gate_q     <= 1'b0;
      act_div4_q <= 1'b0;
      act_fsel_q <= 2'd0;
    end else begin
      run_q    <= run_d;
      bitpos_q <= bitpos_d;
      lr_q     <= lr_d;
      gate_q   <= gate_d;
      if (act_load) begin
        act_div4_q <= cfg_div4;
        act_fsel_q <= cfg_fsel;
      end
    end
  end

  p_bitpos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bitpos_q <= fs_last);
  p_lr_on_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr_q) |-> $past(launch_now || !en));
  p_ratio_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_fsel_q) || !$stable(act_div4_q)) |-> (bitpos_q == '0));
endmodule

// File: rtl/audclk_slvsync.sv
module audclk_slvsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk_in,
  input  logic lrclk_in,
  input  logic bclk_inv,
  input  logic frame_inv,
  output logic launch_q,
  output logic capture_q,
  output logic lr
);
  logic [SYNC_STAGES-1:0] bsh_q, bsh_d, lsh_q, lsh_d;
  logic bprev_q, b_now, b_prev, launch_d, capture_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign bsh_d = bclk_in;
      assign lsh_d = lrclk_in;
    end else begin : g_many
      assign bsh_d = {bsh_q[SYNC_STAGES-2:0], bclk_in};
      assign lsh_d = {lsh_q[SYNC_STAGES-2:0], lrclk_in};
    end
  endgenerate

  always_comb begin
    b_now     = bsh_q[SYNC_STAGES-1] ^ bclk_inv;
    b_prev    = bprev_q ^ bclk_inv;
    launch_d  = en && b_prev && !b_now;
    capture_d = en && !b_prev && b_now;
    lr        = lsh_q[SYNC_STAGES-1] ^ frame_inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsh_q     <= '0;
      lsh_q     <= '0;
      bprev_q   <= 1'b0;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
    end else begin
      bsh_q     <= bsh_d;
      lsh_q     <= lsh_d;
      bprev_q   <= bsh_q[SYNC_STAGES-1];
      launch_q  <= launch_d;
      capture_q <= capture_d;
    end
  end

  p_slave_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!launch_q && !capture_q));
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
  parameter int ACTIVE_BITS = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_mst,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cfg_master,
  input  logic       cfg_bclk_inv,
  input  logic       cfg_frame_inv,
  input  logic       cfg_free_run,
  input  logic       cfg_bdiv_sel,
  input  logic [1:0] cfg_fdiv_sel,
  input  logic       bclk_in,
  input  logic       lrclk_in,
  output logic       bclk_o,
  output logic       bclk_oe,
  output logic       lrclk_o,
  output logic       lrclk_oe,
  output logic       launch_stb,
  output logic       capture_stb,
  output logic       frame_lr
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rsync_q;
  logic rst_n_s, en_m, en_s;
  logic m_launch_now, m_capture_now, m_launch_q, m_capture_q, m_raw_q;
  logic m_div4, m_lr_q, m_gate_q;
  logic s_launch_q, s_capture_q, s_lr;

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rsync_q[RST_STAGES-1];

  assign en_m = enable && cfg_master;
  assign en_s = enable && !cfg_master;

  audclk_bitdiv u_bitdiv (
    .clk         (clk_mst),
    .rst_n       (rst_n_s),
    .en          (en_m),
    .div4        (m_div4),
    .launch_now  (m_launch_now),
    .capture_now (m_capture_now),
    .launch_q    (m_launch_q),
    .capture_q   (m_capture_q),
    .raw_q       (m_raw_q)
  );

  audclk_framediv #(.ACTIVE_BITS(ACTIVE_BITS)) u_framediv (
    .clk        (clk_mst),
    .rst_n      (rst_n_s),
    .en         (en_m),
    .launch_now (m_launch_now),
    .cfg_div4   (cfg_bdiv_sel),
    .cfg_fsel   (cfg_fdiv_sel),
    .free_run   (cfg_free_run),
    .act_div4_q (m_div4),
    .lr_q       (m_lr_q),
    .gate_q     (m_gate_q)
  );

  audclk_slvsync #(.SYNC_STAGES(SYNC_STAGES)) u_slvsync (
    .clk       (clk_mst),
    .rst_n     (rst_n_s),
    .en        (en_s),
    .bclk_in   (bclk_in),
    .lrclk_in  (lrclk_in),
    .bclk_inv  (cfg_bclk_inv),
    .frame_inv (cfg_frame_inv),
    .launch_q  (s_launch_q),
    .capture_q (s_capture_q),
    .lr        (s_lr)
  );

  always_comb begin
    bclk_o      = (m_raw_q | m_gate_q) ^ cfg_bclk_inv;
    lrclk_o     = m_lr_q ^ cfg_frame_inv;
    bclk_oe     = cfg_master;
    lrclk_oe    = cfg_master;
    launch_stb  = cfg_master ? m_launch_q  : s_launch_q;
    capture_stb = cfg_master ? m_capture_q : s_capture_q;
    frame_lr    = cfg_master ? m_lr_q      : s_lr;
  end

  p_gate_idle_r5: assert property (@(posedge clk_mst) disable iff (!rst_n_s)
    (cfg_master && m_gate_q) |-> (bclk_o == !cfg_bclk_inv));
  p_master_unused_in_slave_r3: assert property (@(posedge clk_mst) disable iff (!rst_n_s)
    !cfg_master |=> (!m_launch_q && !m_lr_q));
endmodule

// File: tb/audclk_gen_tb.sv
module audclk_gen_tb;
  localparam int GATE_FROM = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic enable = 1'b0, cfg_master = 1'b1, cfg_bclk_inv = 1'b0, cfg_frame_inv = 1'b0;
  logic cfg_free_run = 1'b1, cfg_bdiv_sel = 1'b0;
  logic [1:0] cfg_fdiv_sel = 2'd0;
  logic bclk_in = 1'b0, lrclk_in = 1'b0;
  logic bclk_o, bclk_oe, lrclk_o, lrclk_oe, launch_stb, capture_stb, frame_lr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R9";

  audclk_gen u_dut (
    .clk_mst(clk), .rst_n(rst_n), .enable(enable), .cfg_master(cfg_master),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_frame_inv(cfg_frame_inv),
    .cfg_free_run(cfg_free_run), .cfg_bdiv_sel(cfg_bdiv_sel),
    .cfg_fdiv_sel(cfg_fdiv_sel), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .lrclk_o(lrclk_o), .lrclk_oe(lrclk_oe),
    .launch_stb(launch_stb), .capture_stb(capture_stb), .frame_lr(frame_lr)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  int  rcnt = 0, ph = 0, bp = 0, S = 2, F = 32;
  bit  mrun = 0, mraw = 1, mgate = 0, mlr = 0, ml = 0, mc = 0, sl = 0, sc = 0;
  bit  bh[$] = '{0, 0, 0};
  bit  lh[$] = '{0, 0, 0};

  function automatic int bit_ratio(input logic s);
    return s ? 4 : 2;
  endfunction
  function automatic int frm_ratio(input logic [1:0] s);
    return (s == 0) ? 32 : (s == 1) ? 64 : 128;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt++;
      mrun = 0; mraw = 1; mgate = 0; mlr = 0; ml = 0; mc = 0; sl = 0; sc = 0;
      bh = '{0, 0, 0}; lh = '{0, 0, 0};
    end else begin
      // slave path: bh[0] newest sample
      sl = enable && !cfg_master && (bh[2] ^ cfg_bclk_inv) && !(bh[1] ^ cfg_bclk_inv);
      sc = enable && !cfg_master && !(bh[2] ^ cfg_bclk_inv) && (bh[1] ^ cfg_bclk_inv);
      bh.push_front(bclk_in);  void'(bh.pop_back());
      lh.push_front(lrclk_in); void'(lh.pop_back());
      // master path
      if (enable && cfg_master) begin
        if (!mrun) begin
          mrun = 1; ph = 0; bp = 0;
          S = bit_ratio(cfg_bdiv_sel); F = frm_ratio(cfg_fdiv_sel);
        end else begin
          ph++;
          if (ph == S) begin
            ph = 0; bp++;
            if (bp == F) begin
              bp = 0; S = bit_ratio(cfg_bdiv_sel); F = frm_ratio(cfg_fdiv_sel);
            end
          end
        end
        ml = (ph == 0); mc = (ph == S / 2); mraw = (ph >= S / 2);
        if (ml) begin
          mlr   = (bp >= F / 2);
          mgate = !cfg_free_run && ((bp % (F / 2)) >= GATE_FROM);
        end
      end else begin
        mrun = 0; ml = 0; mc = 0; mraw = 1; mlr = 0; mgate = 0;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic [6:0] act, exp;
    act = {bclk_o, bclk_oe, lrclk_o, lrclk_oe, launch_stb, capture_stb, frame_lr};
    exp = {(mraw | mgate) ^ cfg_bclk_inv, cfg_master, mlr ^ cfg_frame_inv, cfg_master,
           cfg_master ? ml : sl, cfg_master ? mc : sc,
           cfg_master ? mlr : (lh[1] ^ cfg_frame_inv)};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      if (n_bad < 20)
        $display("FAIL %s cycle %0d: {bclk,oe,lrclk,oe,launch,capture,lr} actual %b expected %b",
                 tag, cyc, act, exp);
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_slave(input int n, input int bper, input int lper);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (i % bper == 0) bclk_in = ~bclk_in;
      if (i % lper == 0) lrclk_in = ~lrclk_in;
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    run(5);
    tag = "R9"; rst_n = 1'b1; run(4);          // R9: idle through release
    tag = "R1"; enable = 1'b1; run(300);       // R1: /2, frame 32
    tag = "R6"; enable = 1'b0; run(20);        // R6: stop to idle
    tag = "R1"; cfg_bdiv_sel = 1'b1; cfg_fdiv_sel = 2'd1; enable = 1'b1; run(600);
    tag = "R6"; enable = 1'b0; run(3); enable = 1'b1; run(7); enable = 1'b0; run(1);
    tag = "R2"; cfg_bdiv_sel = 1'b0; cfg_fdiv_sel = 2'd2; enable = 1'b1; run(600);
    tag = "R2"; enable = 1'b0; run(2); cfg_fdiv_sel = 2'd3; enable = 1'b1; run(600);
    tag = "R4"; cfg_bclk_inv = 1'b1; cfg_frame_inv = 1'b1; run(300);
    cfg_bclk_inv = 1'b0; cfg_frame_inv = 1'b0;
    tag = "R5"; enable = 1'b0; run(2); cfg_fdiv_sel = 2'd1; cfg_free_run = 1'b0;
    enable = 1'b1; run(400);
    tag = "R5"; cfg_fdiv_sel = 2'd2; cfg_bdiv_sel = 1'b1; run(1200);
    cfg_free_run = 1'b1;
    tag = "R8"; cfg_fdiv_sel = 2'd0; cfg_bdiv_sel = 1'b0; run(100);
    cfg_fdiv_sel = 2'd1; cfg_bdiv_sel = 1'b1; run(37);   // mid-frame change
    cfg_fdiv_sel = 2'd0; run(700);
    tag = "R7"; cfg_free_run = 1'b0; cfg_bclk_inv = 1'b1; run(500);
    cfg_free_run = 1'b1; cfg_bclk_inv = 1'b0;
    tag = "R3"; cfg_master = 1'b0; run_slave(400, 3, 96);
    cfg_bclk_inv = 1'b1; cfg_frame_inv = 1'b1; run_slave(200, 5, 64);
    tag = "R6"; enable = 1'b0; run_slave(100, 2, 32);
    tag = "R3"; cfg_bclk_inv = 1'b0; cfg_frame_inv = 1'b0; enable = 1'b1; cfg_master = 1'b1;
    run(200);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule